// File: doc/BRIEF.md
# Cascadable FIFO Cell with Ring Ownership Tokens

This block is one storage cell of a deeper FIFO built from several identical cells wired in a ring. Every cell sees the same write strobe, write data and read strobe. A cell accepts a write only while it owns the write token, and drives read data only while it owns the read token. When a cell writes its last storage slot, it hands the write token to the next cell. When it reads its last slot, it hands the read token on in the same way. Data therefore fills and drains the cells in turn, and the ring behaves as a single FIFO whose depth is the sum of the cells' depths.

Each cell holds two small state machines, one per token. Each has the states TOK_IDLE and TOK_HELD. The transition *grab* (TOK_IDLE to TOK_HELD) fires on a handoff pulse from the previous cell. The transition *pass* (TOK_HELD to TOK_IDLE) fires on an accepted operation at the last slot, and that operation also raises the one-cycle handoff pulse towards the next cell. At reset, the cell whose lead input is high starts in TOK_HELD for both tokens, and every other cell starts in TOK_IDLE.

With the solo input high, the token machines are bypassed and the cell is an ordinary FIFO. In that mode, bit 0 of the handoff output carries a half-full indication. Replay of stored data is not part of this block.

Top module: `xfifo_cell`

## Requirements
- R1: In the first cycle after reset, every cell is empty, no handoff pulse is raised, and only the cell with first_load high, or any cell in solo mode, owns the write and read tokens.
- R2: A write strobe stores din only in the cell that owns the write token and is not full. All other cells leave their contents unchanged.
- R3: A write accepted at a cell's last slot (address DEPTH-1) raises xp_out[0] for exactly that cycle. The next cell, whose xp_in[0] sees the pulse, owns the write token from the following cycle.
- R4: A read accepted at a cell's last slot raises xp_out[1] for exactly that cycle. The read token moves to the next cell in the same way.
- R5: dout_vld is high only in the cell that owns the read token and holds data. dout then shows the oldest word of that cell, and dout is zero whenever dout_vld is low.
- R6: Words written across cell boundaries come out of the ring in the order they were written.
- R7: With solo high, the tokens are bypassed. xp_out[0] is 1 exactly when the cell holds more than DEPTH/2 words, and xp_out[1] stays 0.
- R8: A write while the owning cell is full is ignored. A ring of N cells therefore holds at most N*DEPTH words.
- R9: A read strobe while the ring is empty is ignored, and dout_vld stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| solo | input | 1 | 1: stand-alone FIFO, tokens bypassed |
| first_load | input | 1 | 1: this cell starts with both tokens |
| wr_en | input | 1 | Write strobe shared by the ring |
| din | input | W | Write data shared by the ring |
| rd_en | input | 1 | Read strobe shared by the ring |
| xp_in | input | 2 | Handoff from previous cell: [0] write token, [1] read token |
| xp_out | output | 2 | Handoff to next cell; in solo mode [0] is the half-full flag |
| dout | output | W | Oldest word while dout_vld, else zero |
| dout_vld | output | 1 | This cell drives read data |
| full | output | 1 | Local storage full |
| empty | output | 1 | Local storage empty |

## Verification
The hardest case to reach from the ports is a ring that is completely full: the write token has wrapped back to the lead cell while that cell's oldest word is still unread, so the ring has to refuse the write. A second hard case is reading from a full ring while a write is offered in the same cycle. The stimulus fills the ring past its capacity with directed writes, drains it past empty with directed reads, and then runs long random phases with opposite write and read biases. These phases drive the ring into full and empty repeatedly and move both tokens around the ring several times. A solo cell is exercised on its own to reach the half-full threshold from both sides.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
    typedef enum logic {
        TOK_IDLE = 1'b0,
        TOK_HELD = 1'b1
    } tok_state_e;
endpackage

// File: rtl/xfifo_token.sv
module xfifo_token
    import xfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic start_held,
    input  logic grab,
    input  logic fire,
    input  logic at_last,
    output logic held,
    output logic pass
);
    tok_state_e state_q;
    tok_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= start_held ? TOK_HELD : TOK_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_IDLE: if (grab && !bypass)            state_d = TOK_HELD;
            TOK_HELD: if (fire && at_last && !bypass) state_d = TOK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        held = bypass || (state_q == TOK_HELD);
        pass = !bypass && (state_q == TOK_HELD) && fire && at_last;
    end
endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         full,
    output logic                         empty,
    output logic                         wr_last,
    output logic                         rd_last
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (push) wptr <= wr_last ? '0 : wptr + AW'(1);
            if (pop)  rptr <= rd_last ? '0 : rptr + AW'(1);
            if (push && !pop)      occ <= occ + CW'(1);
            else if (pop && !push) occ <= occ - CW'(1);
        end
    end

    always_comb begin
        rdata   = mem[rptr];
        full    = (occ == CW'(DEPTH));
        empty   = (occ == '0);
        wr_last = (wptr == AW'(DEPTH-1));
        rd_last = (rptr == AW'(DEPTH-1));
    end
endmodule

// File: rtl/xfifo_cell.sv
module xfifo_cell #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         solo,
    input  logic         first_load,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    input  logic         rd_en,
    input  logic [1:0]   xp_in,
    output logic [1:0]   xp_out,
    output logic [W-1:0] dout,
    output logic         dout_vld,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH+1);

    logic           wtok_held, rtok_held;
    logic           wpass, rpass;
    logic           wr_fire, rd_fire;
    logic           wr_last, rd_last;
    logic [W-1:0]   rdata;
    logic [CW-1:0]  occ;
    logic           half;

    xfifo_token u_wtok (
        .clk(clk), .rst_n(rst_n), .bypass(solo), .start_held(first_load),
        .grab(xp_in[0]), .fire(wr_fire), .at_last(wr_last),
        .held(wtok_held), .pass(wpass)
    );

    xfifo_token u_rtok (
        .clk(clk), .rst_n(rst_n), .bypass(solo), .start_held(first_load),
        .grab(xp_in[1]), .fire(rd_fire), .at_last(rd_last),
        .held(rtok_held), .pass(rpass)
    );

    xfifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(wr_fire), .pop(rd_fire),
        .wdata(din), .rdata(rdata), .occ(occ), .full(full), .empty(empty),
        .wr_last(wr_last), .rd_last(rd_last)
    );

    always_comb begin
        wr_fire  = wr_en && wtok_held && !full;
        rd_fire  = rd_en && rtok_held && !empty;
        half     = (occ > CW'(DEPTH/2));
        dout_vld = rtok_held && !empty;
        dout     = dout_vld ? rdata : '0;
        xp_out   = solo ? {1'b0, half} : {rpass, wpass};
    end
endmodule

// File: rtl/xfifo_cell_chk.sv
module xfifo_cell_chk #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       solo,
    input logic                       first_load,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [1:0]                 xp_out,
    input logic [W-1:0]               dout,
    input logic                       dout_vld,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input logic                       wtok_held
);
    localparam int CW = $clog2(DEPTH+1);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (occ == '0) && (wtok_held == (solo || first_load)));

    // R2
    no_foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!solo && !wtok_held && !rd_en) |=> $stable(occ));

    // R3
    wpass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!solo && xp_out[0]) |=> !xp_out[0]);

    // R4
    rpass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!solo && xp_out[1]) |=> !xp_out[1]);

    // R5
    quiet_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> (dout == '0));

    // R7
    solo_rpass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        solo |-> !xp_out[1]);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && !wr_en) |=> (occ == '0));
endmodule

bind xfifo_cell xfifo_cell_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .solo(solo), .first_load(first_load),
    .wr_en(wr_en), .rd_en(rd_en), .xp_out(xp_out), .dout(dout),
    .dout_vld(dout_vld), .occ(occ), .wtok_held(wtok_held)
);

// File: tb/xfifo_cell_tb_top.sv
module xfifo_cell_tb_top;
    localparam int W     = 9;
    localparam int DEPTH = 8;
    localparam int NC    = 3;
    localparam int CAP   = NC * DEPTH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         wr = 1'b0, rd = 1'b0;
    logic [W-1:0] din = '0;
    logic [1:0]   xo [NC];
    logic [W-1:0] dq [NC];
    logic         vl [NC];
    logic         fl [NC];
    logic         em [NC];

    logic         s_wr = 1'b0, s_rd = 1'b0;
    logic [W-1:0] s_din = '0;
    logic [1:0]   s_xo;
    logic [W-1:0] s_dq;
    logic         s_vl, s_fl, s_em;

    xfifo_cell #(.W(W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .solo(1'b0), .first_load(1'b1),
        .wr_en(wr), .din(din), .rd_en(rd), .xp_in(xo[2]), .xp_out(xo[0]),
        .dout(dq[0]), .dout_vld(vl[0]), .full(fl[0]), .empty(em[0]));
    xfifo_cell #(.W(W), .DEPTH(DEPTH)) chain_b (
        .clk(clk), .rst_n(rst_n), .solo(1'b0), .first_load(1'b0),
        .wr_en(wr), .din(din), .rd_en(rd), .xp_in(xo[0]), .xp_out(xo[1]),
        .dout(dq[1]), .dout_vld(vl[1]), .full(fl[1]), .empty(em[1]));
    xfifo_cell #(.W(W), .DEPTH(DEPTH)) chain_c (
        .clk(clk), .rst_n(rst_n), .solo(1'b0), .first_load(1'b0),
        .wr_en(wr), .din(din), .rd_en(rd), .xp_in(xo[1]), .xp_out(xo[2]),
        .dout(dq[2]), .dout_vld(vl[2]), .full(fl[2]), .empty(em[2]));
    xfifo_cell #(.W(W), .DEPTH(DEPTH)) solo_i (
        .clk(clk), .rst_n(rst_n), .solo(1'b1), .first_load(1'b0),
        .wr_en(s_wr), .din(s_din), .rd_en(s_rd), .xp_in(2'b00), .xp_out(s_xo),
        .dout(s_dq), .dout_vld(s_vl), .full(s_fl), .empty(s_em));

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int q[$];
    int sq[$];
    int wcnt = 0, rcnt = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dev_of(int n);
        return (n / DEPTH) % NC;
    endfunction

    function automatic bit at_last_slot(int n);
        return (n % DEPTH) == DEPTH - 1;
    endfunction

    task automatic chain_step(bit w, bit r, logic [W-1:0] d);
        bit aw, ar;
        int wd, rdv;
        @(negedge clk);
        wr = w; rd = r; din = d;
        #2;
        aw  = w && (q.size() < CAP);   // R8
        ar  = r && (q.size() > 0);     // R9
        wd  = dev_of(wcnt);
        rdv = dev_of(rcnt);
        for (int dv = 0; dv < NC; dv++) begin
            // R3 write handoff pulse
            chk(xo[dv][0] == (aw && dv == wd && at_last_slot(wcnt)), "R3", int'(xo[dv][0]), dv);
            // R4 read handoff pulse
            chk(xo[dv][1] == (ar && dv == rdv && at_last_slot(rcnt)), "R4", int'(xo[dv][1]), dv);
            // R5 / R9 read owner drives
            chk(vl[dv] == (q.size() > 0 && dv == rdv), "R5", int'(vl[dv]), dv);
            if (!vl[dv]) chk(dq[dv] == '0, "R5", int'(dq[dv]), 0);
        end
        if (q.size() > 0) chk(int'(dq[rdv]) == q[0], "R6", int'(dq[rdv]), q[0]);
        if (aw) begin q.push_back(int'(d)); wcnt++; end
        if (ar) begin void'(q.pop_front()); rcnt++; end
    endtask

    task automatic solo_step(bit w, bit r, logic [W-1:0] d);
        bit aw, ar;
        @(negedge clk);
        s_wr = w; s_rd = r; s_din = d;
        #2;
        aw = w && (sq.size() < DEPTH);
        ar = r && (sq.size() > 0);
        // R7 half flag and no read pulse
        chk(s_xo[0] == (sq.size() > DEPTH / 2), "R7", int'(s_xo[0]), sq.size());
        chk(s_xo[1] == 1'b0, "R7", int'(s_xo[1]), 0);
        chk(s_vl == (sq.size() > 0), "R9", int'(s_vl), sq.size());
        if (sq.size() > 0) chk(int'(s_dq) == sq[0], "R7", int'(s_dq), sq[0]);
        // R8 solo full flag
        chk(s_fl == (sq.size() == DEPTH), "R8", int'(s_fl), sq.size());
        if (aw) sq.push_back(int'(d));
        if (ar) void'(sq.pop_front());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state at the ports
        for (int dv = 0; dv < NC; dv++) begin
            chk(vl[dv] == 1'b0, "R1", int'(vl[dv]), 0);
            chk(xo[dv] == 2'b00, "R1", int'(xo[dv]), 0);
            chk(em[dv] == 1'b1, "R1", int'(em[dv]), 1);
        end
        chk(s_xo == 2'b00, "R1", int'(s_xo), 0);

        // R2: first word lands only in the lead cell
        chain_step(1'b1, 1'b0, 9'h0a5);
        @(negedge clk);
        wr = 1'b0;
        #2;
        chk(vl[0] == 1'b1 && vl[1] == 1'b0 && vl[2] == 1'b0, "R2", int'({vl[2], vl[1], vl[0]}), 1);
        chain_step(1'b0, 1'b1, '0);

        // R8: overfill the ring, R6 order across cells
        for (int i = 0; i < CAP + 3; i++) chain_step(1'b1, 1'b0, W'(i + 16));
        chk(fl[0] && fl[1] && fl[2], "R8", int'({fl[2], fl[1], fl[0]}), 7);
        // read and write offered together at full
        chain_step(1'b1, 1'b1, 9'h1ff);
        // R9: drain past empty
        for (int i = 0; i < CAP + 3; i++) chain_step(1'b0, 1'b1, '0);
        // write and read together while empty
        chain_step(1'b1, 1'b1, 9'h055);

        // random phases with alternating bias
        for (int i = 0; i < 4000; i++) begin
            int wb;
            wb = ((i / 250) % 2 == 0) ? 75 : 25;
            chain_step(($urandom % 100) < wb, ($urandom % 100) < (100 - wb), W'($urandom));
        end
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;

        // solo cell: R7 threshold crossing, R8 full, R9 empty
        for (int i = 0; i < DEPTH + 2; i++) solo_step(1'b1, 1'b0, W'(i + 100));
        for (int i = 0; i < DEPTH + 2; i++) solo_step(1'b0, 1'b1, '0);
        for (int i = 0; i < 600; i++) solo_step(($urandom % 2) == 0, ($urandom % 3) == 0, W'($urandom));
        @(negedge clk);
        s_wr = 1'b0; s_rd = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule